// File: doc/BRIEF.md
# LCD Power-Up Command Sequencer

This block brings a small monochrome LCD controller out of reset and into a known operating state over a write-only SPI link. A one-cycle start pulse launches the sequence. The block drives the panel's active-low reset low for a fixed time, releases it, and waits a settle interval that is counted in system clocks. It then sends six 8-bit command frames with the data/command line held at the command level. When the last frame is finished it raises a done flag, which stays high until the next start.

The command bytes are built from configuration inputs that are captured when the start pulse is accepted. These inputs are a 3-bit bias value, a 2-bit temperature coefficient, a 7-bit operating voltage and an invert select. Both delays come from a clock-frequency parameter, so the same block can be placed in any clock domain. A downstream pixel streamer can take over the SPI pins once done is high.

Top module: `lcd_pwrup_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, the outputs are as follows: `lcd_rst_n_o`=1, `spi_cs_n_o`=1, `spi_sclk_o`=0, `dc_o`=1, `busy_o`=0 and `done_o`=0.
- R2: An accepted start drives `lcd_rst_n_o` low for exactly ceil(CLK_HZ·RST_US/10^6) clocks, with a minimum of one.
- R3: The first fall of `spi_cs_n_o` comes exactly CLK_HZ·SETTLE_MS/1000 clocks after `lcd_rst_n_o` rises.
- R4: Exactly six frames are sent, in this order: 0x21; 0x10|bias[2:0]; 0x04|tc[1:0]; 0x80|vop[6:0]; 0x20; and last 0x0C when `invert_i`=0 or 0x0D when `invert_i`=1.
- R5: `dc_o` is 0 whenever `spi_cs_n_o` is 0, and it returns to 1 once the sequence is finished.
- R6: The SPI link runs in mode 0 and sends each byte MSB first. Each low period of `spi_cs_n_o` has exactly 8 rising edges of `spi_sclk_o`, and `spi_sclk_o` is 0 whenever `spi_cs_n_o` is 1.
- R7: The configuration inputs are sampled on the accepted start. Changing them while `busy_o` is high does not change the bytes that are sent.
- R8: `busy_o` goes high in the cycle after an accepted start and stays high until `done_o` rises. `done_o` then stays high, with `busy_o` low, until the next accepted start.
- R9: A start pulse while `busy_o` is high is ignored. The panel reset is not pulsed again and the frame count stays at six.
- R10: A start that arrives while `done_o` is high runs the whole sequence again, using the newly applied configuration.

Parameters: `CLK_HZ` (system clock frequency in Hz), `RST_US` (reset low time in µs), `SETTLE_MS` (settle time in ms), `SCLK_HALF` (system clocks per SPI clock phase).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | One-cycle request to run the power-up sequence |
| bias_i | input | 3 | Bias field for the bias command |
| tcoef_i | input | 2 | Temperature coefficient field |
| vop_i | input | 7 | Operating voltage field |
| invert_i | input | 1 | 1 selects the inverted display mode |
| lcd_rst_n_o | output | 1 | Active-low panel reset |
| spi_sclk_o | output | 1 | SPI clock, idles low |
| spi_mosi_o | output | 1 | SPI serial data out |
| spi_cs_n_o | output | 1 | Active-low SPI chip select, one low period per byte |
| dc_o | output | 1 | Data/command select, 0 for command bytes |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, held until the next start |

## Verification
The bench counts the exact number of clocks the panel reset is held low and the exact gap from reset release to the first chip-select fall. A delay counter that is off by one load value would show up as a gap one clock too long or too short. Inputs at their masking limits (bias 7, coefficient 3, voltage 127) and both invert settings expose any field that spills into a neighbouring opcode bit. Changing the configuration in the middle of a run, and pulsing start during both the settle wait and the byte transfers, catch a design that samples its inputs late or restarts itself. That would appear as wrong bytes, a second reset pulse or more than six frames.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int unsigned NUM_CMDS = 6;
    localparam int unsigned IDX_W    = $clog2(NUM_CMDS);

    // opcode building blocks
    localparam logic [7:0] OP_FUNC     = 8'h20;
    localparam logic [7:0] OP_EXT_BIT  = 8'h01;
    localparam logic [7:0] OP_BIAS     = 8'h10;
    localparam logic [7:0] OP_TEMP     = 8'h04;
    localparam logic [7:0] OP_VOLT     = 8'h80;
    localparam logic [7:0] OP_DISP     = 8'h08;
    localparam logic [7:0] DISP_NORMAL = 8'h04;
    localparam logic [7:0] DISP_INVERT = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RST    = 3'd1,
        ST_SETTLE = 3'd2,
        ST_LOAD   = 3'd3,
        ST_WAIT   = 3'd4,
        ST_DONE   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic [2:0] bias;
        logic [1:0] tcoef;
        logic [6:0] vop;
        logic       invert;
    } panel_cfg_t;

endpackage

// File: rtl/lcd_delay_timer.sv
module lcd_delay_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_cmd_select.sv
module lcd_cmd_select
    import lcd_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  panel_cfg_t       cfg_i,
    output logic [7:0]       byte_o
);

    always_comb begin
        unique case (idx_i)
            3'd0:    byte_o = OP_FUNC | OP_EXT_BIT;
            3'd1:    byte_o = OP_BIAS | {5'b0, cfg_i.bias};
            3'd2:    byte_o = OP_TEMP | {6'b0, cfg_i.tcoef};
            3'd3:    byte_o = OP_VOLT | {1'b0, cfg_i.vop};
            3'd4:    byte_o = OP_FUNC;
            default: byte_o = OP_DISP | (cfg_i.invert ? DISP_INVERT : DISP_NORMAL);
        endcase
    end

endmodule

// File: rtl/lcd_spi_tx.sv
module lcd_spi_tx #(
    parameter int unsigned SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    output logic       idle_o,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       cs_n_o
);

    localparam int unsigned DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

    typedef struct packed {
        logic          active;
        logic          cs_n;
        logic          sclk;
        logic [7:0]    shreg;
        logic [2:0]    bitn;
        logic [DW-1:0] div;
    } tx_regs_t;

    tx_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!cur_q.active) begin
            if (start_i) begin
                nxt_d.active = 1'b1;
                nxt_d.cs_n   = 1'b0;
                nxt_d.sclk   = 1'b0;
                nxt_d.shreg  = byte_i;
                nxt_d.bitn   = '0;
                nxt_d.div    = '0;
            end
        end else if (cur_q.div == DW'(SCLK_HALF - 1)) begin
            nxt_d.div = '0;
            if (!cur_q.sclk) begin
                nxt_d.sclk = 1'b1;
            end else begin
                nxt_d.sclk = 1'b0;
                if (cur_q.bitn == 3'd7) begin
                    nxt_d.cs_n   = 1'b1;
                    nxt_d.active = 1'b0;
                end else begin
                    nxt_d.bitn  = cur_q.bitn + 1'b1;
                    nxt_d.shreg = {cur_q.shreg[6:0], 1'b0};
                end
            end
        end else begin
            nxt_d.div = cur_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{active: 1'b0, cs_n: 1'b1, sclk: 1'b0,
                       shreg: 8'h00, bitn: 3'd0, div: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign idle_o = !cur_q.active;
    assign sclk_o = cur_q.sclk;
    assign cs_n_o = cur_q.cs_n;
    assign mosi_o = cur_q.cs_n ? 1'b0 : cur_q.shreg[7];

    // R6
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cs_n |-> !cur_q.sclk);

    // R6
    frame_end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.active && cur_q.sclk && cur_q.bitn == 3'd7 && cur_q.div == DW'(SCLK_HALF - 1))
        |=> (cur_q.cs_n && !cur_q.sclk));

endmodule

// File: rtl/lcd_pwrup_seq.sv
module lcd_pwrup_seq
    import lcd_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned RST_US    = 20,
    parameter int unsigned SETTLE_MS = 120,
    parameter int unsigned SCLK_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] bias_i,
    input  logic [1:0] tcoef_i,
    input  logic [6:0] vop_i,
    input  logic       invert_i,
    output logic       lcd_rst_n_o,
    output logic       spi_sclk_o,
    output logic       spi_mosi_o,
    output logic       spi_cs_n_o,
    output logic       dc_o,
    output logic       busy_o,
    output logic       done_o
);

    localparam longint unsigned RST_RAW    = (64'(CLK_HZ) * 64'(RST_US) + 64'd999_999) / 64'd1_000_000;
    localparam longint unsigned RST_CYC    = (RST_RAW == 0) ? 64'd1 : RST_RAW;
    localparam longint unsigned SETTLE_CYC = (64'(CLK_HZ) * 64'(SETTLE_MS)) / 64'd1000;
    localparam longint unsigned MAX_CYC    = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
    localparam int unsigned     TW         = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        panel_cfg_t       cfg;
        logic             dc;
    } seq_regs_t;

    seq_regs_t     cur_q, nxt_d;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic          tx_start;
    logic          tx_idle;
    logic [7:0]    tx_byte;

    lcd_delay_timer #(.TW(TW)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    lcd_cmd_select cmd_i (
        .idx_i  (cur_q.idx),
        .cfg_i  (cur_q.cfg),
        .byte_o (tx_byte)
    );

    lcd_spi_tx #(.SCLK_HALF(SCLK_HALF)) tx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_start),
        .byte_i  (tx_byte),
        .idle_o  (tx_idle),
        .sclk_o  (spi_sclk_o),
        .mosi_o  (spi_mosi_o),
        .cs_n_o  (spi_cs_n_o)
    );

    always_comb begin
        nxt_d    = cur_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tx_start = 1'b0;
        unique case (cur_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    nxt_d.state  = ST_RST;
                    nxt_d.idx    = '0;
                    nxt_d.cfg    = '{bias: bias_i, tcoef: tcoef_i, vop: vop_i, invert: invert_i};
                    tmr_load     = 1'b1;
                    tmr_val      = TW'(RST_CYC - 1);
                end
            end
            ST_RST: begin
                if (tmr_expired) begin
                    nxt_d.state = ST_SETTLE;
                    tmr_load    = 1'b1;
                    // one clock of the wait is spent in ST_LOAD
                    tmr_val     = TW'(SETTLE_CYC - 2);
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    nxt_d.state = ST_LOAD;
                    nxt_d.dc    = 1'b0;
                end
            end
            ST_LOAD: begin
                tx_start    = 1'b1;
                nxt_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (tx_idle) begin
                    if (cur_q.idx == IDX_W'(NUM_CMDS - 1)) begin
                        nxt_d.state = ST_DONE;
                        nxt_d.dc    = 1'b1;
                    end else begin
                        nxt_d.idx   = cur_q.idx + 1'b1;
                        nxt_d.state = ST_LOAD;
                    end
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, idx: '0, cfg: '0, dc: 1'b1};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign lcd_rst_n_o = (cur_q.state != ST_RST);
    assign busy_o      = (cur_q.state inside {ST_RST, ST_SETTLE, ST_LOAD, ST_WAIT});
    assign done_o      = (cur_q.state == ST_DONE);
    assign dc_o        = cur_q.dc;

    // R5
    cmd_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n_o |-> !dc_o);

    // R2
    panel_rst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n_o |-> busy_o);

    // R6
    cs_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n_o |-> busy_o);

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cur_q.state != ST_WAIT) |=> $stable(cur_q.cfg));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_SETTLE && start_i) |=> (cur_q.state inside {ST_SETTLE, ST_LOAD}));

    // R3
    settle_to_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_SETTLE && tmr_expired) |=> ##1 !spi_cs_n_o);

endmodule

// File: tb/lcd_pwrup_seq_tb_top.sv
module lcd_pwrup_seq_tb_top;

    localparam int unsigned CLK_HZ    = 100_000;
    localparam int unsigned RST_US    = 20;
    localparam int unsigned SETTLE_MS = 120;
    localparam int unsigned SCLK_HALF = 2;
    localparam int RST_EXP    = 2;      // ceil(100000*20/1e6)
    localparam int SETTLE_EXP = 12000;  // 100000*120/1000

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [2:0] bias_i;
    logic [1:0] tcoef_i;
    logic [6:0] vop_i;
    logic       invert_i;
    logic       lcd_rst_n_o, spi_sclk_o, spi_mosi_o, spi_cs_n_o, dc_o, busy_o, done_o;

    always #4 clk = ~clk;

    lcd_pwrup_seq #(
        .CLK_HZ(CLK_HZ), .RST_US(RST_US), .SETTLE_MS(SETTLE_MS), .SCLK_HALF(SCLK_HALF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .bias_i(bias_i), .tcoef_i(tcoef_i), .vop_i(vop_i), .invert_i(invert_i),
        .lcd_rst_n_o(lcd_rst_n_o), .spi_sclk_o(spi_sclk_o), .spi_mosi_o(spi_mosi_o),
        .spi_cs_n_o(spi_cs_n_o), .dc_o(dc_o), .busy_o(busy_o), .done_o(done_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // monitor state
    int  cyc = 0;
    int  rst_falls = 0;
    int  rst_low = 0;
    int  rel_cyc = 0;
    bit  await_cs = 0;
    int  frames = 0;
    int  bitcnt = 0;
    logic [7:0] shreg = 0;
    bit  dc_bad = 0;
    logic p_lrst = 1, p_cs = 1, p_sclk = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (p_lrst && !lcd_rst_n_o) begin
                rst_falls++;
                rst_low = 0;
            end
            if (!lcd_rst_n_o) rst_low++;
            if (!p_lrst && lcd_rst_n_o) begin
                check(rst_low == RST_EXP, "R2 reset low clocks", rst_low, RST_EXP);
                rel_cyc  = cyc;
                await_cs = 1;
            end
            if (p_cs && !spi_cs_n_o) begin
                if (await_cs) begin
                    check(cyc - rel_cyc == SETTLE_EXP, "R3 settle gap", cyc - rel_cyc, SETTLE_EXP);
                    await_cs = 0;
                end
                bitcnt = 0;
                shreg  = 0;
                dc_bad = 0;
            end
            if (!spi_cs_n_o) begin
                if (dc_o) dc_bad = 1;
                if (!p_sclk && spi_sclk_o) begin
                    shreg = {shreg[6:0], spi_mosi_o};
                    bitcnt++;
                end
            end
            if (spi_cs_n_o && spi_sclk_o)
                check(0, "R6 sclk high while deselected", 1, 0);
            if (!p_cs && spi_cs_n_o) begin
                frames++;
                check(bitcnt == 8, "R6 clocks per frame", bitcnt, 8);
                check(!dc_bad, "R5 dc low during frame", dc_bad, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R4/R9 unexpected frame", shreg, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(shreg == e, "R4 command byte", shreg, e);
                end
            end
            p_lrst = lcd_rst_n_o;
            p_cs   = spi_cs_n_o;
            p_sclk = spi_sclk_o;
        end
    end

    task automatic pulse_start();
        @(posedge clk) #1 start_i = 1'b1;
        @(posedge clk) #1 start_i = 1'b0;
    endtask

    task automatic run_seq(input logic [2:0] b, input logic [1:0] t, input logic [6:0] v,
                           input logic inv, input bit disturb);
        int fb, rb;
        exp_q.push_back(8'h21);
        exp_q.push_back(8'h10 | {5'b0, b});
        exp_q.push_back(8'h04 | {6'b0, t});
        exp_q.push_back(8'h80 | {1'b0, v});
        exp_q.push_back(8'h20);
        exp_q.push_back(inv ? 8'h0D : 8'h0C);
        fb = frames;
        rb = rst_falls;
        bias_i = b; tcoef_i = t; vop_i = v; invert_i = inv;
        pulse_start();
        if (disturb) begin
            // R7: scramble configuration right after acceptance
            bias_i = ~b; tcoef_i = ~t; vop_i = ~v; invert_i = ~inv;
        end
        @(negedge clk);
        check(busy_o && !done_o, "R8 busy after start", {busy_o, done_o}, 2'b10);
        if (disturb) begin
            repeat (100) @(posedge clk);
            pulse_start();                    // R9 during settle
            wait (frames == fb + 2);
            pulse_start();                    // R9 during transfers
        end
        while (!done_o) @(negedge clk);
        check(!busy_o, "R8 busy low at done", busy_o, 0);
        check(dc_o == 1'b1, "R5 dc high after sequence", dc_o, 1);
        check(frames - fb == 6, "R9 frame count", frames - fb, 6);
        check(rst_falls - rb == 1, "R9 single reset pulse", rst_falls - rb, 1);
        check(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
        repeat (20) @(negedge clk);
        check(done_o && !busy_o, "R8 done held", {busy_o, done_o}, 2'b01);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0;
        bias_i = 3'd4; tcoef_i = 2'd0; vop_i = 7'd0; invert_i = 1'b0;
        repeat (4) @(negedge clk);
        // R1 during reset
        check({lcd_rst_n_o, spi_cs_n_o, spi_sclk_o, dc_o, busy_o, done_o} == 6'b110100,
              "R1 reset outputs", {lcd_rst_n_o, spi_cs_n_o, spi_sclk_o, dc_o, busy_o, done_o}, 6'b110100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({lcd_rst_n_o, spi_cs_n_o, spi_sclk_o, dc_o, busy_o, done_o} == 6'b110100,
              "R1 idle outputs", {lcd_rst_n_o, spi_cs_n_o, spi_sclk_o, dc_o, busy_o, done_o}, 6'b110100);
        // defaults, normal display
        run_seq(3'd4, 2'd0, 7'd0, 1'b0, 1'b0);
        // R7 and R9 disturbances, inverted display; R10 rerun after done
        run_seq(3'd3, 2'd2, 7'h55, 1'b1, 1'b1);
        // R10: masking limits on another rerun
        run_seq(3'd7, 2'd3, 7'h7F, 1'b0, 1'b0);
        finish_run();
    end

endmodule